// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a down-counting watchdog that guards a processor against running away. Software sets a 16-bit reload value, a prescale divider and a set of expiry actions. From then on it must keep sending restart commands before the counter runs out. If the counter reaches zero and then takes one more tick, the block fires whichever actions are enabled. The actions are a sticky interrupt, a low pulse on an active-low overflow pin, and a reset-request pulse. Any mix of the three may be enabled.

Every write carries an 8-bit key in its top byte. A write whose key does not match is dropped and leaves only a sticky key-failure flag behind. This means a stray store from corrupted software cannot disable the watchdog or restart it. Reads return a register one cycle after the request, with a valid strobe. Software can read the configuration, the live counter value and the status flags.

Register addresses: 0 is the configuration register. 1 is the counter value, which is read-only and ignores writes. 2 is restart. 3 is status, and a write to it clears flags.

Top module: `kwdt_top`

## Requirements
- R1: Out of reset, `ovf_n` is 1, `irq` and `rst_req` are 0, the counter is disabled, the reload value is 0xFFFF and all status bits are 0. A read of address 0 returns 0x00FFFF00.
- R2: A write to address 0 is accepted only when bits [31:24] hold 0x23. The fields are: bits [23:8] reload, bits [7:4] prescale select n, bit 3 reset-enable, bit 2 pin-enable, bit 1 interrupt-enable, bit 0 counter enable. An accepted write also loads the counter with the new reload value and clears the prescaler. Address 0 reads back bits [23:0] with zeros above them.
- R3: A write to address 0, 2 or 3 whose key is wrong changes no configuration, counter or flag. It only sets the key-failure status bit, which is bit 2 of address 3.
- R4: While the counter is enabled, the counter ticks once every 2^(2n) cycles. The expiry event happens on the tick taken while the counter is 0. That is 2^(2n)*(reload+1) cycles after the load. The counter then reloads and keeps running.
- R5: A write to address 2 with key 0xC5 restarts the count: it reloads the counter and clears the prescaler, so no expiry occurs while restarts keep coming in time.
- R6: On expiry with interrupt-enable set, `irq` goes to 1 and stays at 1 until a write to address 3 with key 0xC5 and data bit 0 set. Disabling the counter does not clear it.
- R7: On expiry with pin-enable set, `ovf_n` is 0 for exactly 8 cycles, starting the cycle after the expiry edge.
- R8: On expiry with reset-enable set, `rst_req` is 1 for exactly 8 cycles, aligned with the `ovf_n` pulse.
- R9: Every expiry sets the overflow status bit (bit 1 of address 3) even when no action is enabled. Actions that are not enabled do not toggle. Bit 0 of address 3 mirrors `irq`.
- R10: A write to address 3 with key 0xC5 and data bit 1 set clears the key-failure bit. Data bit 0 clears both `irq` and the overflow bit.
- R11: A read presented with `rd_en` returns its data on `rd_data` with `rd_valid` high in the next cycle. Address 1 returns the current counter value.
- R12: While the counter is disabled, the counter value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data; bits [31:24] are the key |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq | output | 1 | Sticky expiry interrupt |
| ovf_n | output | 1 | Active-low overflow pulse pin |
| rst_req | output | 1 | Reset-request pulse |

## Verification
The hardest situation to reach from the ports is one where restarts arrive just before expiry. Here the outputs must stay quiet while the counter comes within a few ticks of zero again and again. The stimulus issues keyed restarts on an 8-cycle spacing against an 11-cycle expiry distance. It then stops and measures the exact cycle of the first interrupt. A second hard case is a sticky interrupt that must survive both disabling the counter and a clear sent with the wrong key. The bench reaches it by letting an expiry happen, stopping the counter, and then sending the bad clear before the good one.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int          KEY_W    = 8;
  localparam logic [7:0]  KEY_MODE = 8'h23;
  localparam logic [7:0]  KEY_CMD  = 8'hC5;
  localparam int          CNT_W    = 16;
  localparam int          PS_W     = 4;

  typedef enum logic [1:0] {
    A_MODE  = 2'd0,
    A_COUNT = 2'd1,
    A_KICK  = 2'd2,
    A_STAT  = 2'd3
  } addr_e;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic [PS_W-1:0]  ps;
    logic             rst_en;
    logic             pin_en;
    logic             irq_en;
    logic             en;
  } mode_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             expire,
  output mode_t            mode,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             irq,
  output logic             ovf_flag,
  output logic             keyfail
);
  localparam int MODE_W = $bits(mode_t);

  logic [KEY_W-1:0] key;
  logic mode_hit, kick_hit, stat_hit;
  logic good_mode, good_kick, good_stat, bad_key;
  logic clr_main, clr_fail;

  assign key       = wr_data[31:32-KEY_W];
  assign mode_hit  = wr_en && (wr_addr == A_MODE);
  assign kick_hit  = wr_en && (wr_addr == A_KICK);
  assign stat_hit  = wr_en && (wr_addr == A_STAT);
  assign good_mode = mode_hit && (key == KEY_MODE);
  assign good_kick = kick_hit && (key == KEY_CMD);
  assign good_stat = stat_hit && (key == KEY_CMD);
  assign bad_key   = (mode_hit && (key != KEY_MODE)) ||
                     (kick_hit && (key != KEY_CMD))  ||
                     (stat_hit && (key != KEY_CMD));
  assign clr_main  = good_stat && wr_data[0];
  assign clr_fail  = good_stat && wr_data[1];

  assign load     = good_mode || good_kick;
  assign load_val = good_mode ? wr_data[8 +: CNT_W] : mode.reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= '0;
      mode.reload <= '1;
    end else if (good_mode) begin
      mode <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      ovf_flag <= 1'b0;
      keyfail  <= 1'b0;
    end else begin
      if (expire && mode.irq_en) irq <= 1'b1;
      else if (clr_main)         irq <= 1'b0;
      if (expire)                ovf_flag <= 1'b1;
      else if (clr_main)         ovf_flag <= 1'b0;
      if (bad_key)               keyfail <= 1'b1;
      else if (clr_fail)         keyfail <= 1'b0;
    end
  end

  // R3: a rejected write is recorded
  a_r3_bad_key_flag: assert property (@(posedge clk) disable iff (rst)
    bad_key |=> keyfail);
  // R3: a rejected configuration write leaves the configuration alone
  a_r3_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (mode_hit && (key != KEY_MODE)) |=> $stable(mode));
  // R6: the interrupt holds until a keyed clear
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_main) |=> irq);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PS_W-1:0]  ps,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam int PRE_W = 2 * ((1 << PS_W) - 1);

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] limit;
  logic             tick;

  assign limit  = ({{(PRE_W-1){1'b0}}, 1'b1} << (2 * ps)) - 1'b1;
  assign tick   = en && (pre == limit);
  assign expire = tick && (cnt == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
      pre <= '0;
    end else if (load) begin
      cnt <= load_val;
      pre <= '0;
    end else if (en) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= (cnt == '0) ? load_val : cnt - 1'b1;
    end
  end

  // R12: a stopped counter holds its value
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt));
  // R5: a load places the reload value in the counter
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int LEN     = 8,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic out
);
  localparam int LW = $clog2(LEN + 1);
  localparam logic IDLE = ACT_LOW;

  logic [LW-1:0] left;
  logic          act;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      act  <= 1'b0;
    end else if (trig) begin
      left <= LW'(LEN - 1);
      act  <= 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
      act  <= 1'b1;
    end else begin
      act  <= 1'b0;
    end
  end

  generate
    if (ACT_LOW) begin : g_low
      always_ff @(posedge clk) begin
        if (rst) out <= IDLE;
        else     out <= ~(trig || (left != '0));
      end
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) out <= IDLE;
        else     out <= trig || (left != '0);
      end
    end
  endgenerate

  // R7/R8: the pulse does not end while cycles remain
  a_r7_stretch: assert property (@(posedge clk) disable iff (rst)
    (act && (left != '0)) |=> act);
  // R7/R8: the output follows the internal active state
  a_r8_polarity: assert property (@(posedge clk) disable iff (rst)
    (out != IDLE) == act);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        irq,
  output logic        ovf_n,
  output logic        rst_req
);
  mode_t            mode;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic             ovf_flag;
  logic             keyfail;

  kwdt_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .expire(expire), .mode(mode), .load(load), .load_val(load_val),
    .irq(irq), .ovf_flag(ovf_flag), .keyfail(keyfail)
  );

  kwdt_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
    .clk(clk), .rst(rst), .en(mode.en), .ps(mode.ps), .load(load),
    .load_val(load_val), .cnt(cnt), .expire(expire)
  );

  kwdt_pulse #(.LEN(PULSE_LEN), .ACT_LOW(1'b1)) u_pin (
    .clk(clk), .rst(rst), .trig(expire && mode.pin_en), .out(ovf_n)
  );

  kwdt_pulse #(.LEN(PULSE_LEN), .ACT_LOW(1'b0)) u_rreq (
    .clk(clk), .rst(rst), .trig(expire && mode.rst_en), .out(rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        unique case (addr_e'(rd_addr))
          A_MODE:  rd_data <= 32'(mode);
          A_COUNT: rd_data <= 32'(cnt);
          A_STAT:  rd_data <= {29'd0, keyfail, ovf_flag, irq};
          default: rd_data <= '0;
        endcase
      end
    end
  end

  // R1: outputs idle in the first cycle after reset
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ovf_n && !rst_req && !irq));
  // R7: the pin only falls when pin-enable was set
  a_r7_pin_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_n) |-> $past(mode.pin_en));
  // R8: the reset request only rises when reset-enable was set
  a_r8_rreq_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(mode.rst_en));
  // R11: read data is valid exactly one cycle after a request
  a_r11_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        irq, ovf_n, rst_req;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  kwdt_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq), .ovf_n(ovf_n), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] md(input logic [7:0] key, input logic [15:0] rl,
                                     input logic [3:0] ps, input logic [3:0] flags);
    return {key, rl, ps, flags};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pop expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected read", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // which: 0 ovf_n low, 1 irq high
  task automatic wait_evt(input int which, output int k);
    k = 0;
    for (int i = 1; i <= 3000; i++) begin
      @(negedge clk);
      if ((which == 0 && ovf_n == 1'b0) || (which == 1 && irq == 1'b1)) begin
        k = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k, nlow, nreq;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ovf_n", {31'd0, ovf_n}, 32'd1);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);
    rd(2'd0, 32'h00FFFF00, "R1 mode reset");
    rd(2'd3, 32'd0, "R1 status reset");

    // R2/R11/R12: keyed configuration, counter readback while stopped
    wr(2'd0, md(8'h23, 16'h1234, 4'd0, 4'b0000));
    rd(2'd0, 32'h00123400, "R2 mode readback");
    rd(2'd1, 32'h00001234, "R11 counter readback");
    repeat (5) @(negedge clk);
    rd(2'd1, 32'h00001234, "R12 counter holds");

    // R3: wrong keys ignored, flag set; R10 clear
    wr(2'd0, md(8'h24, 16'h0003, 4'd0, 4'b1111));
    rd(2'd0, 32'h00123400, "R3 mode unchanged");
    rd(2'd1, 32'h00001234, "R3 counter unchanged");
    rd(2'd3, 32'd4, "R3 keyfail set");
    wr(2'd3, {8'hC5, 24'd2});
    rd(2'd3, 32'd0, "R10 keyfail cleared");

    // R7/R8: pin and reset pulses
    wr(2'd0, md(8'h23, 16'd20, 4'd0, 4'b1101));
    wait_evt(0, k);
    check("R7 pin delay", k, 32'd21);
    check("R8 rst_req with pin", {31'd0, rst_req}, 32'd1);
    nlow = 1; nreq = 1;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (ovf_n == 1'b0) nlow++;
      if (rst_req == 1'b1) nreq++;
    end
    check("R7 pin width", nlow, 32'd8);
    check("R8 rst_req width", nreq, 32'd8);
    check("R9 irq stays low when disabled", {31'd0, irq}, 32'd0);
    wr(2'd0, md(8'h23, 16'd20, 4'd0, 4'b0000));
    wr(2'd3, {8'hC5, 24'd3});

    // R4: prescale n=1, reload 2 -> 12 cycles; R6 stickiness
    wr(2'd0, md(8'h23, 16'd2, 4'd1, 4'b0011));
    wait_evt(1, k);
    check("R4 prescaled expiry", k, 32'd12);
    check("R9 pin stays high", {31'd0, ovf_n}, 32'd1);
    wr(2'd0, md(8'h23, 16'd2, 4'd1, 4'b0000));
    repeat (10) @(negedge clk);
    check("R6 irq sticky", {31'd0, irq}, 32'd1);
    wr(2'd3, {8'h23, 24'd3});
    check("R6 wrong-key clear ignored", {31'd0, irq}, 32'd1);
    rd(2'd3, 32'd7, "R6 status irq+ovf+keyfail");
    wr(2'd3, {8'hC5, 24'd3});
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    rd(2'd3, 32'd0, "R10 status cleared");

    // R5: restarts hold off expiry
    wr(2'd0, md(8'h23, 16'd10, 4'd0, 4'b0011));
    for (int i = 0; i < 5; i++) begin
      repeat (6) @(negedge clk);
      wr(2'd2, {8'hC5, 24'd0});
    end
    check("R5 no expiry under restarts", {31'd0, irq}, 32'd0);
    wait_evt(1, k);
    check("R5 expiry after last restart", k, 32'd11);
    wr(2'd0, md(8'h23, 16'd10, 4'd0, 4'b0000));
    wr(2'd3, {8'hC5, 24'd1});

    // R9: expiry with no actions sets overflow status only
    wr(2'd0, md(8'h23, 16'd3, 4'd0, 4'b0001));
    nlow = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq || !ovf_n || rst_req) nlow++;
    end
    check("R9 no action toggles", nlow, 32'd0);
    wr(2'd0, md(8'h23, 16'd3, 4'd0, 4'b0000));
    rd(2'd3, 32'd2, "R9 overflow status");

    repeat (4) @(negedge clk);
    check("R11 all reads returned", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule